// File: doc/BRIEF.md
# Counter with Asynchronous Preset and Clear

This block is a binary up counter that advances by one on each rising clock edge. It has two controls that act at once, without waiting for a clock edge. An active-high load input copies a preset word into the count. An active-low clear input drives the count to zero. Both controls reach each stage's storage element through its direct set and reset paths, not through the next-state logic. As a result, the count responds the moment a control changes, and it stays forced for as long as the control is held.

The counter is meant for places where a known value has to be imposed between clock edges, for example while the clock is stopped or slowed. When load is released, the next rising edge counts upward from the loaded value. The count wraps from all ones back to zero. Clear always takes precedence over load.

Top module: `async_preset_counter`

## Requirements
- R1: While clear_n is low, count reads 0 at once, with no clock edge needed, and clock edges do not change it.
- R2: Clear ranks above load: with load high and clear_n low the count is 0. Raising clear_n while load stays high makes count equal preset_val at once.
- R3: A rising load with clear_n high makes count equal preset_val before any clock edge.
- R4: While load stays high, clock edges do not advance the count. The count follows any change of preset_val immediately.
- R5: After load falls, the first rising clock edge gives count = loaded value + 1.
- R6: With load low and clear_n high, every rising clock edge adds one to count. Bit 0 toggles on every edge, and bit n toggles when all lower bits are 1.
- R7: From count = all ones (15 for the default width of 4), a counting edge gives 0.
- R8: Asserting load again after counting has resumed reloads preset_val at once.
- R9: Releasing load without a clock edge leaves count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| load_async | input | 1 | Active-high asynchronous load of preset_val |
| clear_n | input | 1 | Active-low asynchronous clear, highest priority |
| preset_val | input | WIDTH | Value forced onto count while loading |
| count | output | WIDTH | Present count |

## Verification
Load values are chosen so that, during the following run of edges, the carry into each upper bit occurs and the count wraps. These runs separate a correct toggle chain from one that drops a carry term or fails to wrap.

Each asynchronous event is checked in the gap between clock edges. A load or clear that acted only on the clock would leave the old value there.

Load held across several edges, including a change of the preset word while it is held, separates a forced hold from a synchronous load. Clear with load still high, and release of clear under load, show which of the two controls has priority.

// File: rtl/apc_pkg.sv
package apc_pkg;
  // Per-bit asynchronous force request produced by the decoder
  typedef enum logic [1:0] {
    FRC_NONE = 2'b00,
    FRC_SET  = 2'b01,
    FRC_CLR  = 2'b10
  } frc_e;
endpackage

// File: rtl/apc_toggle_chain.sv
module apc_toggle_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] tog
);
  // Each bit toggles when every bit below it is one; bit 0 always toggles.
  for (genvar i = 0; i < WIDTH; i++) begin : g_tog
    if (i == 0) begin : g_lsb
      assign tog[i] = 1'b1;
    end else begin : g_upper
      assign tog[i] = &q[i-1:0];
    end
  end
endmodule

// File: rtl/apc_force_decode.sv
module apc_force_decode
  import apc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             load,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] set_a,
  output logic [WIDTH-1:0] rst_a
);
  frc_e req [WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_dec
    always_comb begin
      if (!clear_n)      req[i] = FRC_CLR;
      else if (!load)    req[i] = FRC_NONE;
      else if (preset[i]) req[i] = FRC_SET;
      else               req[i] = FRC_CLR;
    end
    assign set_a[i] = (req[i] == FRC_SET);
    assign rst_a[i] = (req[i] == FRC_CLR);
  end
endmodule

// File: rtl/apc_bit_cell.sv
module apc_bit_cell (
  input  logic clk,
  input  logic set_a,
  input  logic rst_a,
  input  logic tog,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q ^ tog;
  end

  // Direct reset ranks above direct set; both outrank the clock.
  always_ff @(posedge clk or posedge rst_a or posedge set_a) begin
    if (rst_a)      q <= 1'b0;
    else if (set_a) q <= 1'b1;
    else            q <= q_nxt;
  end
endmodule

// File: rtl/async_preset_counter.sv
module async_preset_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             load_async,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] tog;
  logic [WIDTH-1:0] set_a;
  logic [WIDTH-1:0] rst_a;

  apc_toggle_chain #(.WIDTH(WIDTH)) i_chain (
    .q   (count),
    .tog (tog)
  );

  apc_force_decode #(.WIDTH(WIDTH)) i_dec (
    .load    (load_async),
    .clear_n (clear_n),
    .preset  (preset_val),
    .set_a   (set_a),
    .rst_a   (rst_a)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    apc_bit_cell i_cell (
      .clk   (clk),
      .set_a (set_a[i]),
      .rst_a (rst_a[i]),
      .tog   (tog[i]),
      .q     (count[i])
    );
  end

  // Checker state: set when a load or clear has acted since the last edge
  logic async_seen;
  always_ff @(posedge clk or posedge load_async or negedge clear_n) begin
    if (!clear_n)        async_seen <= 1'b1;
    else if (load_async) async_seen <= 1'b1;
    else                 async_seen <= 1'b0;
  end

  always @(posedge clk) begin
    if (!clear_n) begin
      a_r1_clear_zero: assert (count == '0);
    end
  end

  a_r4_hold_preset: assert property (@(posedge clk) disable iff (!clear_n)
    load_async |-> count == preset_val);

  a_r6_increment: assert property (@(posedge clk) disable iff (!clear_n)
    (!load_async && !async_seen) |-> count == WIDTH'($past(count) + 1'b1));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!clear_n)
    (!load_async && !async_seen && $past(count) == '1) |-> count == '0);
endmodule

// File: tb/test_async_preset_counter.sv
`timescale 1ns/100ps
module test_async_preset_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         ld;
  logic         clr_n;
  logic [W-1:0] pv;
  logic [W-1:0] cnt;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  async_preset_counter #(.WIDTH(W)) i_async_preset_counter (
    .clk        (clk),
    .load_async (ld),
    .clear_n    (clr_n),
    .preset_val (pv),
    .count      (cnt)
  );

  typedef struct packed {
    logic [3:0] pre;
    logic [7:0] edges;
    logic [3:0] expv;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'h9, 8'd3,  4'hC},
    '{4'h0, 8'd1,  4'h1},
    '{4'hE, 8'd2,  4'h0},
    '{4'hF, 8'd1,  4'h0},
    '{4'h5, 8'd16, 4'h5},
    '{4'hA, 8'd7,  4'h1}
  };

  task automatic chk(input string req, input logic [W-1:0] expv);
    nchk++;
    if (cnt !== expv) begin
      nfail++;
      $display("FAIL %s: count=%h expected=%h", req, cnt, expv);
    end
  endtask

  task automatic gap();
    @(negedge clk);
  endtask

  task automatic edge_chk(input string req, input logic [W-1:0] expv);
    @(posedge clk);
    #1;
    chk(req, expv);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: count=%h expected=run complete", cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    ld = 1'b0; clr_n = 1'b0; pv = '0;
    #1;
    chk("R1 reset state", 4'h0);
    edge_chk("R1 edge during clear", 4'h0);
    gap(); clr_n = 1'b1;
    edge_chk("R6 first count", 4'h1);
    edge_chk("R6 second count", 4'h2);

    // Table walk: load, release, run edges
    for (int v = 0; v < 6; v++) begin
      gap(); pv = VEC[v].pre; ld = 1'b1; #0.5;
      chk("R3 async load", VEC[v].pre);
      #0.5; ld = 1'b0; #0.5;
      chk("R9 release holds", VEC[v].pre);
      for (int k = 1; k <= int'(VEC[v].edges); k++) begin
        edge_chk(k == 1 ? "R5 first edge after load" : "R6 count", W'(VEC[v].pre + k));
      end
      chk(VEC[v].pre == 4'hE || VEC[v].pre == 4'hF ? "R7 wrap" : "R6 run end", VEC[v].expv);
    end

    // Hold under load, with preset change
    gap(); pv = 4'h9; ld = 1'b1; #0.5;
    chk("R3 load 9", 4'h9);
    edge_chk("R4 hold edge 1", 4'h9);
    edge_chk("R4 hold edge 2", 4'h9);
    gap(); pv = 4'h6; #0.5;
    chk("R4 follows preset", 4'h6);
    edge_chk("R4 hold edge 3", 4'h6);
    gap(); ld = 1'b0;
    edge_chk("R5 after hold", 4'h7);
    edge_chk("R6 after hold", 4'h8);

    // Reload after counting
    gap(); pv = 4'h3; ld = 1'b1; #0.5;
    chk("R8 reload", 4'h3);
    #0.5; ld = 1'b0;
    edge_chk("R5 after reload", 4'h4);

    // Clear mid-count, between edges
    gap(); clr_n = 1'b0; #0.5;
    chk("R1 async clear", 4'h0);
    #0.5; clr_n = 1'b1;
    edge_chk("R6 after clear", 4'h1);

    // Clear against load
    gap(); pv = 4'hB; ld = 1'b1; #0.5;
    chk("R3 load B", 4'hB);
    clr_n = 1'b0; #0.5;
    chk("R2 clear beats load", 4'h0);
    edge_chk("R2 edge under both", 4'h0);
    gap(); clr_n = 1'b1; #0.5;
    chk("R2 clear release under load", 4'hB);
    #0.5; ld = 1'b0;
    edge_chk("R5 after clear and load", 4'hC);

    // Wrap from all ones by counting
    gap(); pv = 4'hD; ld = 1'b1; #0.5; ld = 1'b0;
    edge_chk("R6 to E", 4'hE);
    edge_chk("R6 to F", 4'hF);
    edge_chk("R7 wrap to 0", 4'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule